// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block merges three reasons for holding a processor in reset and drives two complementary reset outputs: `reset_hi`, active high, and `reset_lo_n`, active low. The first reason is a supply-good flag. It comes from an external comparator and is already synchronized. The second is an active-low manual push-button input, which is debounced. The third is a watchdog timer. Software services the watchdog by producing falling edges on a strobe input.

All timing is counted in units of a one-cycle millisecond tick input. A single shared stretch counter holds reset for a fixed number of ticks after the last active source goes away. Any source that asserts again during the stretch restarts the count from zero. The watchdog has three selectable periods and cannot be turned off. While reset is active its counter is held at zero, so the first service window opens when reset is released.

Top module: `wdt_supervisor`

## Requirements
- R1: While `supply_ok` is low, reset is asserted. Reset is active out of `arst_n`, and a low `supply_ok` sampled at a clock edge makes `reset_hi` high after that edge.
- R2: Once every source is inactive, reset stays asserted for exactly `STRETCH_TICKS` ticks and is then released. With a tick on every cycle, `reset_hi` falls `STRETCH_TICKS` clocks after `supply_ok` rises.
- R3: Holding `pb_n` low for more than `DEBOUNCE_TICKS` ticks asserts reset. With a tick on every cycle, reset rises `DEBOUNCE_TICKS`+3 clocks after `pb_n` falls, stays high while `pb_n` is low, and falls `STRETCH_TICKS`+2 clocks after `pb_n` returns high.
- R4: A low pulse on `pb_n` that lasts `DEBOUNCE_TICKS` ticks or fewer has no effect on the reset outputs.
- R5: `wd_sel` picks the watchdog period: 2'b00 gives `WD_SHORT_TICKS`, 2'b01 gives `WD_MID_TICKS`, and 2'b10 or 2'b11 give `WD_LONG_TICKS`.
- R6: Only a high-to-low transition of `strobe` restarts the watchdog window. A strobe held low counts as no service. A falling edge presented before clock edge a restarts the window at edge a+2.
- R7: If the window of L ticks runs out with no service, reset rises exactly L ticks after the window start (its release or its last service). Reset is then held for `STRETCH_TICKS` ticks.
- R8: The watchdog ignores `strobe` while reset is active, and its window restarts from zero at release.
- R9: Any source that asserts during the stretch restarts the stretch count from zero.
- R10: `reset_lo_n` is always the exact complement of `reset_hi`.
- R11: Stretch, debounce and watchdog counts advance only on clocks where `tick_1ms` is high. With no tick, reset is never released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low initialisation of the block |
| tick_1ms | input | 1 | One-cycle timebase pulse, nominally every millisecond |
| supply_ok | input | 1 | Synchronized supply-good flag, high when the supply is in tolerance |
| pb_n | input | 1 | Manual reset request, active low, asynchronous |
| strobe | input | 1 | Watchdog service input; falling edges restart the window |
| wd_sel | input | 2 | Watchdog period select (00 short, 01 mid, 1x long) |
| reset_hi | output | 1 | Reset output, active high |
| reset_lo_n | output | 1 | Reset output, active low |

## Verification
The bench builds the block with `STRETCH_TICKS`=20, `DEBOUNCE_TICKS`=4 and watchdog periods of 12, 30 and 60, and it holds the tick high on most cycles. At these values every release, bite, debounce threshold and stretch restart lands at an exact clock count, and the bench predicts and compares each of those counts. Dropping the tick for a long stretch shows that counting depends on the timebase. The small periods allow all four select codes and a full bite-and-recover cycle to be exercised in a few thousand clocks.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;

   typedef enum logic [1:0] {
      WD_SEL_SHORT = 2'b00,
      WD_SEL_MID   = 2'b01,
      WD_SEL_LONG  = 2'b10
   } wd_sel_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/wdt_sup_sync.sv
module wdt_sup_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("wdt_sup_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain_q <= RESET_VAL;
            else         chain_q <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain_q <= {STAGES{RESET_VAL}};
            else         chain_q <= {chain_q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/wdt_sup_debounce.sv
module wdt_sup_debounce #(
   parameter int DEBOUNCE_TICKS = 10
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   input  logic btn_sync_n,
   output logic press_req
);

   localparam int CW = $clog2(DEBOUNCE_TICKS + 1);

   generate
      if (DEBOUNCE_TICKS < 1 || DEBOUNCE_TICKS >= 20) begin : g_bad_deb
         $error("wdt_sup_debounce: DEBOUNCE_TICKS must lie in 1..19 so a 20-tick press is caught");
      end
   endgenerate

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         low_cnt <= '0;
      end else if (btn_sync_n) begin
         low_cnt <= '0;
      end else if (tick && low_cnt != CW'(DEBOUNCE_TICKS)) begin
         low_cnt <= low_cnt + 1'b1;
      end
   end

   assign press_req = (low_cnt == CW'(DEBOUNCE_TICKS)) && !btn_sync_n;

   AST_DEB_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
      btn_sync_n |=> (low_cnt == '0)); // R4
   AST_DEB_SATURATES: assert property (@(posedge clk) disable iff (!arst_n)
      low_cnt <= CW'(DEBOUNCE_TICKS)); // R4

endmodule

// File: rtl/wdt_sup_watchdog.sv
module wdt_sup_watchdog
   import wdt_sup_pkg::*;
#(
   parameter int SHORT_TICKS = 150,
   parameter int MID_TICKS   = 610,
   parameter int LONG_TICKS  = 1200
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       tick,
   input  logic       in_reset,
   input  logic       strobe_sync,
   input  logic [1:0] sel,
   output logic       bite
);

   localparam int MAXP = max3(SHORT_TICKS, MID_TICKS, LONG_TICKS);
   localparam int WW   = $clog2(MAXP + 1);

   generate
      if (SHORT_TICKS < 2 || MID_TICKS < 2 || LONG_TICKS < 2) begin : g_bad_period
         $error("wdt_sup_watchdog: every period must be at least 2 ticks");
      end
   endgenerate

   logic [WW-1:0] limit;
   logic [WW-1:0] wd_cnt;
   logic          strobe_prev;
   logic          strobe_fall;

   always_comb begin
      case (sel)
         WD_SEL_SHORT: limit = WW'(SHORT_TICKS);
         WD_SEL_MID:   limit = WW'(MID_TICKS);
         default:      limit = WW'(LONG_TICKS);
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) strobe_prev <= 1'b1;
      else         strobe_prev <= strobe_sync;
   end

   assign strobe_fall = strobe_prev && !strobe_sync;
   assign bite        = !in_reset && tick && (wd_cnt >= limit - 1'b1);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         wd_cnt <= '0;
      end else if (in_reset || bite || strobe_fall) begin
         wd_cnt <= '0;
      end else if (tick) begin
         wd_cnt <= wd_cnt + 1'b1;
      end
   end

   AST_WD_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
      in_reset |=> (wd_cnt == '0)); // R8
   AST_WD_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!arst_n)
      (!tick && !in_reset && !strobe_fall) |=> $stable(wd_cnt)); // R11
   AST_WD_FALL_RESTARTS: assert property (@(posedge clk) disable iff (!arst_n)
      (strobe_fall && !in_reset) |=> (wd_cnt == '0)); // R6

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
   parameter int STRETCH_TICKS  = 250,
   parameter int DEBOUNCE_TICKS = 10,
   parameter int WD_SHORT_TICKS = 150,
   parameter int WD_MID_TICKS   = 610,
   parameter int WD_LONG_TICKS  = 1200,
   parameter int SYNC_STAGES    = 2
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       tick_1ms,
   input  logic       supply_ok,
   input  logic       pb_n,
   input  logic       strobe,
   input  logic [1:0] wd_sel,
   output logic       reset_hi,
   output logic       reset_lo_n
);

   localparam int SW = $clog2(STRETCH_TICKS + 1);

   generate
      if (STRETCH_TICKS < 2) begin : g_bad_stretch
         $error("wdt_supervisor: STRETCH_TICKS must be at least 2");
      end
   endgenerate

   logic          pb_sync_n;
   logic          strobe_sync;
   logic          press_req;
   logic          bite;
   logic          src;
   logic          active;
   logic [SW-1:0] stretch_cnt;

   wdt_sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_pb (
      .clk(clk), .arst_n(arst_n), .din(pb_n), .dout(pb_sync_n)
   );

   wdt_sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_st (
      .clk(clk), .arst_n(arst_n), .din(strobe), .dout(strobe_sync)
   );

   wdt_sup_debounce #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_deb (
      .clk(clk), .arst_n(arst_n), .tick(tick_1ms),
      .btn_sync_n(pb_sync_n), .press_req(press_req)
   );

   wdt_sup_watchdog #(
      .SHORT_TICKS(WD_SHORT_TICKS), .MID_TICKS(WD_MID_TICKS), .LONG_TICKS(WD_LONG_TICKS)
   ) u_wd (
      .clk(clk), .arst_n(arst_n), .tick(tick_1ms), .in_reset(active),
      .strobe_sync(strobe_sync), .sel(wd_sel), .bite(bite)
   );

   assign src = !supply_ok || press_req || bite;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         active      <= 1'b1;
         stretch_cnt <= '0;
      end else if (src) begin
         active      <= 1'b1;
         stretch_cnt <= '0;
      end else if (active && tick_1ms) begin
         if (stretch_cnt == SW'(STRETCH_TICKS - 1)) begin
            active      <= 1'b0;
            stretch_cnt <= '0;
         end else begin
            stretch_cnt <= stretch_cnt + 1'b1;
         end
      end
   end

   assign reset_hi   = active;
   assign reset_lo_n = !active;

   AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
      !supply_ok |=> reset_hi); // R1
   AST_SOURCE_RESTARTS: assert property (@(posedge clk) disable iff (!arst_n)
      src |=> (active && stretch_cnt == '0)); // R9
   AST_RELEASE_FULL_COUNT: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(active) |-> ($past(stretch_cnt) == SW'(STRETCH_TICKS - 1))); // R2
   AST_RELEASE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(active) |-> $past(tick_1ms)); // R11

endmodule

// File: tb/tb_wdt_supervisor.sv
module tb_wdt_supervisor;

   localparam int CLK_PERIOD = 10;
   localparam int S  = 20;
   localparam int D  = 4;
   localparam int LS = 12;
   localparam int LM = 30;
   localparam int LL = 60;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       tick_1ms = 1'b1;
   logic       supply_ok = 1'b0;
   logic       pb_n = 1'b1;
   logic       strobe = 1'b1;
   logic [1:0] wd_sel = 2'b00;
   logic       reset_hi;
   logic       reset_lo_n;

   wdt_supervisor #(
      .STRETCH_TICKS(S), .DEBOUNCE_TICKS(D),
      .WD_SHORT_TICKS(LS), .WD_MID_TICKS(LM), .WD_LONG_TICKS(LL), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .arst_n(arst_n), .tick_1ms(tick_1ms), .supply_ok(supply_ok),
      .pb_n(pb_n), .strobe(strobe), .wd_sel(wd_sel),
      .reset_hi(reset_hi), .reset_lo_n(reset_lo_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      bit    level;
      int    cycles;
      string tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   int   cyc = 0;
   int   mark = 0;
   logic prev_hi = 1'b1;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Monitor: complement check every cycle, timed transition scoreboard
   always @(negedge clk) begin
      if (arst_n) begin
         check(reset_lo_n === ~reset_hi, "R10 complement", int'(reset_lo_n), int'(~reset_hi));
         if (q.size() > 0 && reset_hi !== prev_hi) begin
            exp_t it;
            it = q.pop_front();
            check(reset_hi === it.level, {it.tag, " level"}, int'(reset_hi), int'(it.level));
            check((cyc - mark) == it.cycles, {it.tag, " cycles"}, cyc - mark, it.cycles);
            mark = cyc;
         end
      end
      prev_hi = reset_hi;
   end

   task automatic push(input bit level, input int cycles, input string tag);
      exp_t it;
      it.level = level; it.cycles = cycles; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wait_idle();
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic hold_reset();
      wait_idle();
      @(negedge clk);
      supply_ok = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic power_up(input logic [1:0] sel, input string tag);
      hold_reset();
      wd_sel = sel;
      @(negedge clk);
      supply_ok = 1'b1;
      mark = cyc;
      push(1'b0, S, tag);
   endtask

   initial begin
      // reset state
      repeat (2) @(negedge clk);
      check(reset_hi === 1'b1, "R1 reset state hi", int'(reset_hi), 1);
      check(reset_lo_n === 1'b0, "R10 reset state lo_n", int'(reset_lo_n), 0);
      arst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(reset_hi === 1'b1, "R1 supply low holds", int'(reset_hi), 1);

      // R2 stretch, R7 bite on short period then stretch
      power_up(2'b00, "R2 power-up stretch");
      push(1'b1, LS, "R7 short bite (R5 sel 00)");
      push(1'b0, S, "R7 stretch after bite");
      wait_idle();

      // R5 mid and long periods
      power_up(2'b01, "R2 stretch");
      push(1'b1, LM, "R5 sel 01 mid");
      wait_idle();
      power_up(2'b10, "R2 stretch");
      push(1'b1, LL, "R5 sel 10 long");
      wait_idle();
      power_up(2'b11, "R2 stretch");
      push(1'b1, LL, "R5 sel 11 long");
      wait_idle();

      // R6 servicing keeps reset off; restart timing; held low is no service
      strobe = 1'b1;
      power_up(2'b00, "R2 stretch");
      wait_idle();
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); strobe = 1'b0;
         repeat (2) @(negedge clk); strobe = 1'b1;
         repeat (5) @(negedge clk);
      end
      check(reset_hi === 1'b0, "R6 serviced watchdog stays quiet", int'(reset_hi), 0);
      @(negedge clk);
      strobe = 1'b0;
      mark = cyc;
      push(1'b1, LS + 3, "R6 window restart from fall");
      push(1'b0, S, "R7 stretch");
      push(1'b1, LS, "R6 level low is no service");
      wait_idle();

      // R8 strobe edges during stretch are ignored
      hold_reset();
      strobe = 1'b1;
      power_up(2'b00, "R8 stretch with strobe activity");
      push(1'b1, LS, "R8 window starts at release");
      for (int i = 0; i < 3; i++) begin
         repeat (3) @(negedge clk); strobe = 1'b0;
         repeat (2) @(negedge clk); strobe = 1'b1;
      end
      wait_idle();

      // R3 / R4 manual reset
      power_up(2'b10, "R2 stretch");
      wait_idle();
      @(negedge clk); pb_n = 1'b0;
      repeat (D) @(negedge clk); pb_n = 1'b1;
      repeat (15) @(negedge clk);
      check(reset_hi === 1'b0, "R4 short press ignored", int'(reset_hi), 0);
      @(negedge clk); pb_n = 1'b0;
      mark = cyc;
      push(1'b1, D + 3, "R3 press onset");
      wait_idle();
      repeat (10) @(negedge clk);
      check(reset_hi === 1'b1, "R3 held while pressed", int'(reset_hi), 1);
      @(negedge clk); pb_n = 1'b1;
      mark = cyc;
      push(1'b0, S + 2, "R3 release stretch");
      wait_idle();

      // R1 supply drop, R9 restart of stretch
      @(negedge clk); supply_ok = 1'b0;
      mark = cyc;
      push(1'b1, 1, "R1 supply drop");
      wait_idle();
      @(negedge clk); supply_ok = 1'b1;
      repeat (10) @(negedge clk);
      check(reset_hi === 1'b1, "R9 mid-stretch still asserted", int'(reset_hi), 1);
      supply_ok = 1'b0;
      @(negedge clk); supply_ok = 1'b1;
      mark = cyc;
      push(1'b0, S, "R9 stretch restarted");
      wait_idle();

      // R11 no tick, no release
      hold_reset();
      tick_1ms = 1'b0;
      supply_ok = 1'b1;
      repeat (40) @(negedge clk);
      check(reset_hi === 1'b1, "R11 no tick holds reset", int'(reset_hi), 1);
      @(negedge clk); tick_1ms = 1'b1;
      mark = cyc;
      push(1'b0, S, "R11 stretch resumes with tick");
      wait_idle();

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule